// File: doc/BRIEF.md
# Shift-and-Add Address Generator

This is a purely combinational datapath unit that forms addresses for indexed array access. It shifts a base or index operand left by a small amount and adds a second operand. The scaled index can be 1, 2, 4 or 8 times the operand, and the two are fused into one result. In the wide (64-bit) configuration there are also unsigned-word forms, which take only the low 32 bits of the first operand, zero-extend them, and then scale and add. A further form places the zero-extended low word at an arbitrary bit position given by a 6-bit immediate, with no addend.

The unit sits beside the integer ALU. It gets an already-decoded operation select, and its result goes back the same cycle. Sums wrap modulo 2^XLEN and nothing reports a carry. In the 32-bit configuration the unsigned-word forms do not exist, so selecting one raises an illegal flag and forces the result to zero.

Top module: `sa_addr_gen`

## Requirements
- R1: With op_sel[3]=0 and op_sel[2]=0, the result is (src_a << op_sel[1:0]) + src_b, so the scale factor is 1, 2, 4 or 8.
- R2: With op_sel[3]=0 and op_sel[2]=1 (64-bit configuration), the result is (zero-extended src_a[31:0] << op_sel[1:0]) + src_b, and src_a bits above 31 have no effect.
- R3: The code op_sel=4'b0100 (unsigned word, shift 0) yields zero-extended src_a[31:0] + src_b.
- R4: With op_sel[3]=1 (64-bit configuration), the result is zero-extended src_a[31:0] shifted left by shamt_imm (0..63). Bits beyond XLEN are dropped, every other bit is zero, src_b has no effect and op_sel[2:0] are ignored.
- R5: Every sum wraps modulo 2^XLEN with no carry out. For example, all-ones plus one gives zero.
- R6: In the 32-bit configuration, any op with op_sel[3]=1 or op_sel[2]=1 drives illegal_op high and sum_out to zero.
- R7: illegal_op is low for every op in the 64-bit configuration, and for the plain ops in the 32-bit configuration.
- R8: For ops with op_sel[3]=0, shamt_imm has no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_sel | input | 4 | [3] word-place-immediate form, [2] unsigned-word form, [1:0] shift amount |
| src_a | input | XLEN | Operand that is shifted (index) |
| src_b | input | XLEN | Operand that is added (base) |
| shamt_imm | input | 6 | Bit position for the word-place-immediate form |
| sum_out | output | XLEN | Wrapped result |
| illegal_op | output | 1 | Op not available in this configuration |

## Verification
Every shifted-add code is applied to a cross product of operand patterns. The patterns include zero, all ones, a lone sign bit, a lone bit 32, a full low word and two mixed constants. Comparing the plain codes with their unsigned-word twins shows whether the upper half of src_a is masked. The all-ones and sign-bit cases show whether the sum wraps instead of growing. The word-place form is swept over all 64 immediates for each pattern, which covers the drop of bits shifted past bit 63. A second, 32-bit instance receives every code, which separates the illegal codes from the legal ones.

// File: rtl/sa_pkg.sv
// Package: shared op encoding for the shift-and-add address generator.
// Assumes the operation select has already been decoded into these four bits.
package sa_pkg;

    localparam int WORD_W = 32;
    localparam int IMM_W  = 6;

    // Decoded operation select: [3] place-word-immediate, [2] unsigned word, [1:0] shift
    typedef struct packed {
        logic       place_imm;
        logic       uword;
        logic [1:0] scale;
    } sa_op_t;

    // True when the op needs the 64-bit configuration
    function automatic logic needs_wide(input sa_op_t op);
        return op.place_imm | op.uword;
    endfunction

endpackage

// File: rtl/sa_operand_prep.sv
// Operand preparation: zero-extends the low word of the shifted operand for
// unsigned-word forms, chooses the addend and flags ops that this width lacks.
// Assumes XLEN is 32 or 64.
module sa_operand_prep
    import sa_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  sa_op_t            op,
    input  logic [XLEN-1:0]   src_a,
    input  logic [XLEN-1:0]   src_b,
    output logic [XLEN-1:0]   shift_in,
    output logic [XLEN-1:0]   addend,
    output logic              illegal
);

    localparam bit HAS_WIDE = (XLEN > WORD_W);

    logic [XLEN-1:0] word_ext;

    // Zero-extended low word of src_a (identity at 32 bits)
    generate
        if (HAS_WIDE) begin : g_wide
            assign word_ext = {{(XLEN-WORD_W){1'b0}}, src_a[WORD_W-1:0]};
        end else begin : g_narrow
            assign word_ext = src_a;
        end
    endgenerate

    // Pick the shifter input and addend; flag unsupported ops
    always_comb begin
        illegal  = needs_wide(op) & ~HAS_WIDE;
        shift_in = needs_wide(op) ? word_ext : src_a;
        addend   = op.place_imm ? '0 : src_b;
        if (illegal) begin
            shift_in = '0;
            addend   = '0;
        end
    end

    // Guard: for a legal unsigned-word op, shifter input carries no upper bits of src_a
    always_comb begin
        if (!$isunknown(op) && HAS_WIDE && needs_wide(op)) begin
            AST_UWORD_UPPER_CLEAR: assert ((shift_in >> WORD_W) == '0); // R2
        end
    end

endmodule

// File: rtl/sa_shifter.sv
// Logarithmic left shifter: one fixed-distance stage per amount bit; stages whose
// distance reaches XLEN clear the value. Assumes amounts up to 2**IMM_W-1.
module sa_shifter
    import sa_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0]  data_in,
    input  logic [IMM_W-1:0] amount,
    output logic [XLEN-1:0]  data_out
);

    logic [XLEN-1:0] stage [IMM_W+1];

    assign stage[0] = data_in;

    // One stage per amount bit, distance 2**i
    generate
        for (genvar i = 0; i < IMM_W; i++) begin : g_stage
            if ((2 ** i) < XLEN) begin : g_shift
                assign stage[i+1] = amount[i] ? (stage[i] << (2 ** i)) : stage[i];
            end else begin : g_clear
                assign stage[i+1] = amount[i] ? '0 : stage[i];
            end
        end
    endgenerate

    assign data_out = stage[IMM_W];

    // Guard: a nonzero shift always clears bit 0
    always_comb begin
        if (!$isunknown(amount) && amount != '0) begin
            AST_SHIFT_LSB_CLEAR: assert (data_out[0] == 1'b0); // R1
        end
    end

endmodule

// File: rtl/sa_adder.sv
// Wrapping adder: XLEN-bit sum with the carry discarded.
module sa_adder #(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0] op_x,
    input  logic [XLEN-1:0] op_y,
    output logic [XLEN-1:0] sum
);

    // Modular sum, carry dropped
    always_comb begin
        sum = op_x + op_y;
    end

endmodule

// File: rtl/sa_addr_gen.sv
// Top: shift-and-add address generator. Selects the shift distance (scale or
// immediate), prepares operands, shifts and adds. Fully combinational.
// Assumes XLEN is 32 or 64 and that op_sel is already decoded.
module sa_addr_gen
    import sa_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic [3:0]       op_sel,
    input  logic [XLEN-1:0]  src_a,
    input  logic [XLEN-1:0]  src_b,
    input  logic [5:0]       shamt_imm,
    output logic [XLEN-1:0]  sum_out,
    output logic             illegal_op
);

    sa_op_t            op;
    logic [XLEN-1:0]   shift_in;
    logic [XLEN-1:0]   addend;
    logic [XLEN-1:0]   shifted;
    logic [IMM_W-1:0]  distance;
    logic              illegal;

    assign op = sa_op_t'(op_sel);

    // Shift distance: immediate for the place form, else the 2-bit scale
    always_comb begin
        distance = op.place_imm ? shamt_imm : {{(IMM_W-2){1'b0}}, op.scale};
    end

    sa_operand_prep #(.XLEN(XLEN)) u_prep (
        .op       (op),
        .src_a    (src_a),
        .src_b    (src_b),
        .shift_in (shift_in),
        .addend   (addend),
        .illegal  (illegal)
    );

    sa_shifter #(.XLEN(XLEN)) u_shift (
        .data_in  (shift_in),
        .amount   (distance),
        .data_out (shifted)
    );

    sa_adder #(.XLEN(XLEN)) u_add (
        .op_x (shifted),
        .op_y (addend),
        .sum  (sum_out)
    );

    assign illegal_op = illegal;

    // Guards relating ports across the sub-blocks
    always_comb begin
        if (!$isunknown({op_sel, src_a, src_b, shamt_imm})) begin
            if (illegal_op) begin
                AST_ILLEGAL_ZERO: assert (sum_out == '0); // R6
                AST_ILLEGAL_WIDE_ONLY: assert (op_sel[3] | op_sel[2]); // R7
            end
            if (op_sel == 4'b0000) begin
                AST_PLAIN_ADD: assert (sum_out == src_a + src_b); // R1
            end
            if (op_sel[3] && !illegal_op && shamt_imm != 6'd0) begin
                AST_PLACE_LSB_ZERO: assert (sum_out[0] == 1'b0); // R4
            end
        end
    end

endmodule

// File: tb/sa_addr_gen_bench.sv
module sa_addr_gen_bench;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic [3:0]  op_sel;
    logic [63:0] a64, b64;
    logic [5:0]  imm;
    logic [63:0] sum64;
    logic        ill64;
    logic [31:0] sum32;
    logic        ill32;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    sa_addr_gen #(.XLEN(64)) u_sa_addr_gen (
        .op_sel(op_sel), .src_a(a64), .src_b(b64), .shamt_imm(imm),
        .sum_out(sum64), .illegal_op(ill64));

    sa_addr_gen #(.XLEN(32)) u_sa_addr_gen_32 (
        .op_sel(op_sel), .src_a(a64[31:0]), .src_b(b64[31:0]), .shamt_imm(imm),
        .sum_out(sum32), .illegal_op(ill32));

    function automatic logic [63:0] pat(input int i);
        case (i)
            0: return 64'h0;
            1: return 64'hFFFF_FFFF_FFFF_FFFF;
            2: return 64'h8000_0000_0000_0000;
            3: return 64'h0000_0000_FFFF_FFFF;
            4: return 64'h0000_0001_0000_0000;
            5: return 64'h0123_4567_89AB_CDEF;
            6: return 64'hFEDC_BA98_7654_3210;
            default: return 64'h7FFF_FFFF_FFFF_FFFF;
        endcase
    endfunction

    // Arithmetic model of the 64-bit configuration
    function automatic logic [63:0] model64(input logic [3:0] o, input logic [63:0] a,
                                            input logic [63:0] b, input logic [5:0] sh);
        logic [127:0] prod;
        logic [63:0]  z;
        z = a & 64'h0000_0000_FFFF_FFFF;
        if (o[3]) begin
            prod = {64'h0, z} * (128'd1 << sh);
            return prod[63:0];
        end
        return (o[2] ? z : a) * (64'd1 << o[1:0]) + b;
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s op=%b a=%h b=%h imm=%0d actual=%h expected=%h",
                     req, op_sel, a64, b64, imm, act, exp);
        end
    endtask

    task automatic apply(input logic [3:0] o, input logic [63:0] a,
                         input logic [63:0] b, input logic [5:0] sh);
        @(negedge clk);
        op_sel = o; a64 = a; b64 = b; imm = sh;
        #2;
    endtask

    initial begin
        op_sel = 4'h0; a64 = '0; b64 = '0; imm = '0;
        #3;
        check("R7 idle", {63'h0, ill64}, 64'h0);
        check("R1 idle", sum64, 64'h0);

        // R1 R2 R3 R8: shifted-add codes over the operand cross product
        for (int o = 0; o < 8; o++) begin
            for (int i = 0; i < 8; i++) begin
                for (int j = 0; j < 8; j++) begin
                    apply(4'(o), pat(i), pat(j), 6'((i * 8 + j + o) % 64));
                    check(o[2] ? (o[1:0] == 0 ? "R3" : "R2") : "R1", sum64,
                          model64(4'(o), pat(i), pat(j), 6'd0));
                    check("R7", {63'h0, ill64}, 64'h0);
                    check(o[2] ? "R6" : "R7 narrow", {63'h0, ill32}, {63'h0, o[2]});
                    check(o[2] ? "R6 zero" : "R1 narrow", {32'h0, sum32},
                          o[2] ? 64'h0 : {32'h0, 32'(model64(4'(o), pat(i), pat(j), 6'd0))});
                end
            end
        end

        // R4: place-word form, all immediates, src_b must not matter
        for (int i = 0; i < 8; i++) begin
            for (int s = 0; s < 64; s++) begin
                apply(4'b1000 | 4'(s % 8), pat(i), pat((i + s) % 8), 6'(s));
                check("R4", sum64, model64(4'b1000, pat(i), 64'h0, 6'(s)));
                check("R6", {63'h0, ill32}, 64'h1);
                check("R6 zero", {32'h0, sum32}, 64'h0);
            end
        end

        // R5: explicit wrap cases
        apply(4'b0000, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 6'd0);
        check("R5 wrap", sum64, 64'h0);
        apply(4'b0011, 64'h8000_0000_0000_0001, 64'h0, 6'd0);
        check("R5 wrap scaled", sum64, 64'h8);
        apply(4'b0001, 64'hFFFF_FFFF, 64'hFFFF_FFFF, 6'd0);
        check("R5 narrow wrap", {32'h0, sum32}, 64'hFFFF_FFFD);

        // R8: immediate extremes give identical results
        apply(4'b0110, 64'hDEAD_BEEF_1234_5678, 64'h10, 6'd0);
        check("R8 imm0", sum64, 64'h0000_0000_48D1_59F0);
        apply(4'b0110, 64'hDEAD_BEEF_1234_5678, 64'h10, 6'd63);
        check("R8 imm63", sum64, 64'h0000_0000_48D1_59F0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule